// File: doc/BRIEF.md
# Latch-Based Dual-Port Register File

A small storage array of four words, four bits each, with one write port and one independent read port. The write port takes a word address, a data word and an active-low write strobe. While the strobe is low the addressed word is open and follows the data input level by level; when the strobe returns high the last value is kept. Storage is built from level-sensitive latches, not edge-triggered flops, so the block has no clock and no reset.

The read port is fully combinational. An active-low read enable selects whether the output is driven: when enabled, the word at the read address appears unchanged on the data output and a drive flag is high; when disabled, the flag is low and the data is forced to zero. The flag stands in for a three-state output, so a wrapper outside the block can turn it into a floating bus. Because an open latch passes its input straight through, reading the word that is being written shows the incoming data at once.

Several copies may share an output bus for more words, as long as their read enables are never low together, or run side by side on shared address and enable lines for wider words. Stored contents are undefined until first written.

Top module: `latch_regfile`

## Requirements
- R1: Each of the four words (write and read address 0 to 3, binary) stores its own 4-bit value; a value written to an address is read back from that same address.
- R2: While wr_en_n is low, the word at wr_addr follows wr_data continuously, including changes in the middle of the low pulse; the value present when wr_en_n rises is kept.
- R3: While wr_en_n is high, wr_data and wr_addr have no effect and every stored word keeps its value.
- R4: While rd_en_n is low, rd_drive is 1 and rd_data equals the stored word at rd_addr, bit for bit in true (non-inverted) form.
- R5: While rd_en_n is high, rd_drive is 0 and rd_data is all zeros, whatever the address and contents.
- R6: The read address works independently of both enables: reading one word while another is being written shows the read word's stored value.
- R7: When rd_addr equals wr_addr while wr_en_n is low and rd_en_n is low, rd_data shows wr_data combinationally, not the old contents.
- R8: wr_addr must stay stable while wr_en_n is low; a write pulse with a stable address changes only the addressed word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_en_n | input | 1 | Write strobe, active low; addressed word is open while low |
| wr_addr | input | 2 | Word address for the write port |
| wr_data | input | 4 | Data presented to the addressed word |
| rd_en_n | input | 1 | Read enable, active low; output driven while low |
| rd_addr | input | 2 | Word address for the read port |
| rd_data | output | 4 | Selected word when driven, zero otherwise |
| rd_drive | output | 1 | High while the output is driven (three-state enable) |

## Verification
A walk of mixed write and read steps fills every word with a distinct, non-symmetric value and then reads them back at other addresses, which separates address decoding faults and inverted or swapped bits from correct storage. Steps that read a different word than the one being written tell true port independence from an output that leaks write data, while steps with equal addresses show the flow-through of an open latch. Changing the data in the middle of a held-low strobe separates level-sensitive storage from edge capture, and sweeping address and data with the strobe high, then reading all words back, shows that the idle write port touches nothing. Toggling the read enable over stored data checks that the drive flag and the zeroed output follow it alone.

// File: rtl/lrf_pkg.sv
package lrf_pkg;

  localparam int LRF_DEF_WORDS = 4;
  localparam int LRF_DEF_WIDTH = 4;

  // Address width needed for a given number of words (at least one bit).
  function automatic int lrf_addr_bits(input int words);
    int bits;
    bits = 1;
    while ((1 << bits) < words) bits++;
    return bits;
  endfunction

endpackage

// File: rtl/lrf_wr_decode.sv
module lrf_wr_decode #(
  parameter int WORDS = lrf_pkg::LRF_DEF_WORDS,
  parameter int AW    = lrf_pkg::lrf_addr_bits(WORDS)
) (
  input  logic             wr_en_n,
  input  logic [AW-1:0]    wr_addr,
  output logic [WORDS-1:0] wr_open
);

  // One open line per word: active while the strobe is low and the
  // address selects this word.
  function automatic logic addr_hits(input logic [AW-1:0] a, input int idx);
    return (a == idx[AW-1:0]);
  endfunction

  for (genvar g = 0; g < WORDS; g++) begin : g_dec
    assign wr_open[g] = ~wr_en_n & addr_hits(wr_addr, g);
  end

endmodule

// File: rtl/lrf_word_latch.sv
module lrf_word_latch #(
  parameter int WIDTH = lrf_pkg::LRF_DEF_WIDTH
) (
  input  logic             open_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  // Transparent while open, holds otherwise.
  always_latch begin
    if (open_i) q_o = d_i;
  end

endmodule

// File: rtl/lrf_read_port.sv
module lrf_read_port #(
  parameter int WORDS = lrf_pkg::LRF_DEF_WORDS,
  parameter int WIDTH = lrf_pkg::LRF_DEF_WIDTH,
  parameter int AW    = lrf_pkg::lrf_addr_bits(WORDS)
) (
  input  logic [WORDS-1:0][WIDTH-1:0] words_i,
  input  logic [AW-1:0]               rd_addr,
  input  logic                        rd_en_n,
  output logic [WIDTH-1:0]            rd_data,
  output logic                        rd_drive
);

  logic [WIDTH-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (rd_addr == i[AW-1:0]) sel_word = words_i[i];
    end
  end

  assign rd_drive = ~rd_en_n;
  assign rd_data  = rd_drive ? sel_word : '0;

endmodule

// File: rtl/latch_regfile.sv
module latch_regfile #(
  parameter int WORDS = lrf_pkg::LRF_DEF_WORDS,
  parameter int WIDTH = lrf_pkg::LRF_DEF_WIDTH,
  localparam int AW   = lrf_pkg::lrf_addr_bits(WORDS)
) (
  input  logic             wr_en_n,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en_n,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_drive
);

  // Named internal events for the checker.
  logic [WORDS-1:0]            wr_open;
  logic [WORDS-1:0][WIDTH-1:0] word_q;

  lrf_wr_decode #(.WORDS(WORDS), .AW(AW)) u_dec (
    .wr_en_n (wr_en_n),
    .wr_addr (wr_addr),
    .wr_open (wr_open)
  );

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    lrf_word_latch #(.WIDTH(WIDTH)) u_word (
      .open_i (wr_open[g]),
      .d_i    (wr_data),
      .q_o    (word_q[g])
    );
  end

  lrf_read_port #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_rd (
    .words_i  (word_q),
    .rd_addr  (rd_addr),
    .rd_en_n  (rd_en_n),
    .rd_data  (rd_data),
    .rd_drive (rd_drive)
  );

endmodule

// File: rtl/lrf_checker.sv
module lrf_checker #(
  parameter int WORDS = lrf_pkg::LRF_DEF_WORDS,
  parameter int WIDTH = lrf_pkg::LRF_DEF_WIDTH,
  parameter int AW    = lrf_pkg::lrf_addr_bits(WORDS)
) (
  input logic                        wr_en_n,
  input logic [AW-1:0]               wr_addr,
  input logic [WIDTH-1:0]            wr_data,
  input logic                        rd_en_n,
  input logic [AW-1:0]               rd_addr,
  input logic [WIDTH-1:0]            rd_data,
  input logic                        rd_drive,
  input logic [WORDS-1:0]            wr_open,
  input logic [WORDS-1:0][WIDTH-1:0] word_q
);

  // Address seen just before the strobe went low.
  logic [AW-1:0] held_addr;
  always_latch begin
    if (wr_en_n) held_addr = wr_addr;
  end

  always_comb begin
    // R8: address must not move while the strobe is low
    if (!wr_en_n) begin
      a_r8_waddr_stable: assert (wr_addr == held_addr)
        else $error("write address changed during write pulse");
    end
    // R3: no word is open while the strobe is high; at most one otherwise
    a_r3_open_onehot: assert ($onehot0(wr_open) && (!wr_en_n || wr_open == '0))
      else $error("write open lines wrong");
    // R2: the addressed word follows the data input while open
    if (!wr_en_n) begin
      a_r2_follow: assert (word_q[wr_addr] == wr_data)
        else $error("open word does not follow data");
    end
    // R5: disabled output is off and zero
    if (rd_en_n) begin
      a_r5_off_zero: assert (!rd_drive && rd_data == '0)
        else $error("output driven while read disabled");
    end
    // R7: flow-through from the word being written
    if (!wr_en_n && !rd_en_n && rd_addr == wr_addr) begin
      a_r7_flow: assert (rd_drive && rd_data == wr_data)
        else $error("no flow-through on same address");
    end
  end

endmodule

bind latch_regfile lrf_checker #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_chk (
  .wr_en_n  (wr_en_n),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_en_n  (rd_en_n),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .rd_drive (rd_drive),
  .wr_open  (wr_open),
  .word_q   (word_q)
);

// File: tb/latch_regfile_bench.sv
module latch_regfile_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic       clk = 1'b0;
  logic       wr_en_n = 1'b1;
  logic [1:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic       rd_en_n = 1'b1;
  logic [1:0] rd_addr = '0;
  logic [3:0] rd_data;
  logic       rd_drive;

  int n_run = 0;
  int n_fail = 0;
  logic [3:0] mdl [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  latch_regfile u_latch_regfile (
    .wr_en_n  (wr_en_n),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en_n  (rd_en_n),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_drive (rd_drive)
  );

  // Vector: {we_n, waddr, wdata, re_n, raddr}
  typedef struct packed {
    logic       we_n;
    logic [1:0] wa;
    logic [3:0] wd;
    logic       re_n;
    logic [1:0] ra;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd0, 4'hA, 1'b1, 2'd0},
    '{1'b0, 2'd1, 4'h5, 1'b0, 2'd0},
    '{1'b0, 2'd2, 4'hC, 1'b0, 2'd1},
    '{1'b0, 2'd3, 4'h3, 1'b0, 2'd2},
    '{1'b0, 2'd0, 4'h6, 1'b0, 2'd0},
    '{1'b1, 2'd0, 4'hF, 1'b0, 2'd3},
    '{1'b1, 2'd2, 4'h9, 1'b0, 2'd0},
    '{1'b0, 2'd2, 4'h9, 1'b0, 2'd2},
    '{1'b1, 2'd0, 4'h0, 1'b0, 2'd1},
    '{1'b1, 2'd0, 4'h0, 1'b0, 2'd2},
    '{1'b1, 2'd0, 4'h0, 1'b1, 2'd2},
    '{1'b0, 2'd1, 4'h0, 1'b1, 2'd1},
    '{1'b1, 2'd0, 4'h0, 1'b0, 2'd1},
    '{1'b0, 2'd3, 4'hF, 1'b0, 2'd3},
    '{1'b1, 2'd0, 4'h0, 1'b0, 2'd0},
    '{1'b1, 2'd1, 4'hE, 1'b0, 2'd3}
  };

  task automatic check(input string tag, input logic [3:0] exp_q, input logic exp_drv);
    n_run++;
    if (rd_data !== exp_q || rd_drive !== exp_drv) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h rd_drive=%b expected rd_data=%h rd_drive=%b",
               tag, rd_data, rd_drive, exp_q, exp_drv);
    end
  endtask

  // Expected output from the requirements and the bench's own word copy.
  function automatic logic [3:0] expect_q();
    if (rd_en_n) return 4'h0;
    if (!wr_en_n && rd_addr == wr_addr) return wr_data;
    return mdl[rd_addr];
  endfunction

  // Strobe goes high first so addresses only change while it is high.
  task automatic apply(input vec_t v);
    wr_en_n = 1'b1;
    #1;
    wr_addr = v.wa; wr_data = v.wd; rd_en_n = v.re_n; rd_addr = v.ra;
    #1;
    wr_en_n = v.we_n;
    @(negedge clk);
    if (!wr_en_n) mdl[wr_addr] = wr_data;
  endtask

  task automatic read_word(input logic [1:0] a);
    rd_en_n = 1'b0; rd_addr = a;
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mdl[i] = 4'h0;
    @(negedge clk);
    // Idle state: read disabled (R5)
    check("R5 idle output off", 4'h0, 1'b0);

    // Table walk: R1 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i]);
      check($sformatf("R1 R4 R5 R6 R7 vector %0d", i), expect_q(), ~rd_en_n);
    end
    wr_en_n = 1'b1;
    #2;

    // R1: read all words back after the walk
    for (int a = 0; a < 4; a++) begin
      read_word(a[1:0]);
      check($sformatf("R1 readback word %0d", a), mdl[a], 1'b1);
    end

    // R2: transparency within a held-low pulse, then hold
    @(negedge clk);
    wr_addr = 2'd1; wr_data = 4'h7; rd_addr = 2'd1; rd_en_n = 1'b0;
    #1; wr_en_n = 1'b0; #2;
    check("R2 open word follows 7", 4'h7, 1'b1);
    wr_data = 4'h8; #2;
    check("R2 open word follows 8", 4'h8, 1'b1);
    wr_en_n = 1'b1; #1;
    wr_data = 4'h2; #2;
    check("R2 last value held", 4'h8, 1'b1);
    mdl[1] = 4'h8;

    // R3: sweep the write port with the strobe high
    for (int a = 0; a < 4; a++) begin
      wr_addr = a[1:0]; wr_data = 4'(a * 5 + 1); #2;
    end
    for (int a = 0; a < 4; a++) begin
      read_word(a[1:0]);
      check($sformatf("R3 word %0d untouched", a), mdl[a], 1'b1);
    end

    // R4: non-inverted pattern, and R5 disable over stored data
    @(negedge clk);
    wr_addr = 2'd0; wr_data = 4'b0001; #1; wr_en_n = 1'b0; #1; wr_en_n = 1'b1;
    mdl[0] = 4'b0001;
    read_word(2'd0);
    check("R4 true form 0001", 4'b0001, 1'b1);
    rd_en_n = 1'b1; #2;
    check("R5 disabled over stored word", 4'h0, 1'b0);

    // R8: stable-address pulse to word 2 changes only word 2
    @(negedge clk);
    wr_addr = 2'd2; wr_data = 4'hB; #1; wr_en_n = 1'b0; #2; wr_en_n = 1'b1; #1;
    mdl[2] = 4'hB;
    for (int a = 0; a < 4; a++) begin
      read_word(a[1:0]);
      check($sformatf("R8 word %0d after pulse to word 2", a), mdl[a], 1'b1);
    end

    // R6: write word 3 while reading word 0
    @(negedge clk);
    rd_addr = 2'd0; rd_en_n = 1'b0; wr_addr = 2'd3; wr_data = 4'h4;
    #1; wr_en_n = 1'b0; #2;
    check("R6 read other word during write", mdl[0], 1'b1);
    wr_en_n = 1'b1; #2;
    mdl[3] = 4'h4;
    read_word(2'd3);
    check("R6 written word stored", 4'h4, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule